// File: doc/BRIEF.md
# Serial NOR Flash Write-Protection Guard

This block holds the protection state of a serial NOR flash status register and checks every byte-program request against it. Commands arrive already deserialized, one opcode byte and one data byte per cycle on a command strobe. Four commands are decoded: set the write-enable latch (0x06), clear it (0x04), write the status register (0x01) and read it (0x05). Other opcodes are ignored.

The protect field BP selects a power-of-two count of sectors, 2^(BP-1), with BP = 0 protecting nothing. The count saturates at the array size. A direction bit anchors the protected range at the high end of the array (0) or at the low end (1). Two per-part parameters decide whether the direction bit and the fourth protect bit exist. When a part lacks one of them, that bit reads as zero and writes to it are dropped. A program request that passes the check is forwarded to the memory array one cycle later. Its data is ANDed with the byte the array already holds, because programming can only clear bits. A request that fails the check is dropped and raises a one-cycle error pulse.

Top module: `spi_wp_guard`

## Requirements
- R1: After reset the status register reads 0x00, and neither `mem_we` nor `prot_err` is asserted.
- R2: Opcode 0x06 sets status bit 1 (write-enable latch) and opcode 0x04 clears it. Opcode 0x05 makes `sr_rd_valid` high on the next cycle, with `sr_rd_data` equal to the status register: bit 7 write-disable, bit 6 BP3, bit 5 direction, bits 4:2 BP2..BP0, bit 1 latch, bit 0 zero.
- R3: Opcode 0x01 with the latch set stores bits 7 and 4:2 of `cmd_data` and clears the latch. With the latch clear it changes nothing.
- R4: When HAS_DIR is 1, bit 5 of the written byte is stored and reported. When HAS_DIR is 0, bit 5 always reads 0 and the range is anchored at the high end.
- R5: When HAS_BP3 is 1, bit 6 of the written byte is stored as BP3 and reported. When HAS_BP3 is 0, bit 6 always reads 0 and BP3 is taken as 0.
- R6: With BP = 0, no sector is protected.
- R7: With the direction bit at 0 and BP > 0, sector s = addr / sector size is protected when s + 2^(BP-1) >= NUM_SECTORS.
- R8: With the direction bit at 1 and BP > 0, sector s is protected when s < 2^(BP-1).
- R9: When 2^(BP-1) is at least NUM_SECTORS, every sector is protected, with no wrap-around of the count.
- R10: An accepted program request gives, one cycle later, a one-cycle `mem_we` with the same `mem_addr` and `mem_wdata` = `prog_data` AND `mem_rdata`. A request to a protected sector gives a one-cycle `prot_err` instead, and `mem_we` stays low.
- R11: A program request made while the latch is clear produces neither `mem_we` nor `prot_err`. Any program request made while the latch is set clears the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_op | input | 8 | Command opcode |
| cmd_data | input | 8 | Data byte for status write |
| prog_valid | input | 1 | Byte program request |
| prog_addr | input | ADDR_W (25) | Byte address of the request |
| prog_data | input | 8 | Byte to program |
| mem_rdata | input | 8 | Current array contents at `prog_addr` |
| sr_rd_valid | output | 1 | Status read result valid |
| sr_rd_data | output | 8 | Status read result |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W (25) | Array write address |
| mem_wdata | output | 8 | Array write data |
| prot_err | output | 1 | Protected-write rejection pulse |

## Verification
The checker assumes that `cmd_valid` and `prog_valid` are never high in the same cycle. It also assumes that `mem_rdata` is valid in the cycle of the program request. The stimulus issues exactly one operation per cycle and drives the old byte together with the request, so both assumptions hold. Two instances run side by side, one with both optional bits and one with neither, on the same byte stream. Random addresses are biased toward both ends of the array, where the range boundaries lie.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;
   typedef enum logic [7:0] {
      OP_WRSR = 8'h01,
      OP_WRDI = 8'h04,
      OP_RDSR = 8'h05,
      OP_WREN = 8'h06
   } wp_op_e;

   // Field order mirrors the status byte, MSB first.
   typedef struct packed {
      logic       wdis;
      logic       bp3;
      logic       dir;
      logic [2:0] bp_lo;
      logic       wel;
      logic       busy;
   } wp_sr_t;
endpackage

// File: rtl/wp_status_reg.sv
module wp_status_reg
   import spi_wp_pkg::*;
#(
   parameter bit HAS_DIR = 1'b1,
   parameter bit HAS_BP3 = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] load_val,
   input  logic       set_wel,
   input  logic       clr_wel,
   output wp_sr_t     sr
);
   wp_sr_t     nv;
   logic       wel_q, wdis_q;
   logic [2:0] bp_lo_q;
   logic       dir_bit, bp3_bit;

   assign nv = wp_sr_t'(load_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q   <= 1'b0;
         wdis_q  <= 1'b0;
         bp_lo_q <= '0;
      end else begin
         if (load) begin
            wdis_q  <= nv.wdis;
            bp_lo_q <= nv.bp_lo;
         end
         if (clr_wel)      wel_q <= 1'b0;
         else if (set_wel) wel_q <= 1'b1;
      end
   end

   generate
      if (HAS_DIR) begin : g_dir
         logic dir_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    dir_q <= 1'b0;
            else if (load) dir_q <= nv.dir;
         end
         assign dir_bit = dir_q;
      end else begin : g_no_dir
         assign dir_bit = 1'b0;
      end

      if (HAS_BP3) begin : g_bp3
         logic bp3_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    bp3_q <= 1'b0;
            else if (load) bp3_q <= nv.bp3;
         end
         assign bp3_bit = bp3_q;
      end else begin : g_no_bp3
         assign bp3_bit = 1'b0;
      end
   endgenerate

   always_comb begin
      sr       = '0;
      sr.wdis  = wdis_q;
      sr.bp3   = bp3_bit;
      sr.dir   = dir_bit;
      sr.bp_lo = bp_lo_q;
      sr.wel   = wel_q;
      sr.busy  = 1'b0;
   end
endmodule

// File: rtl/wp_range_check.sv
module wp_range_check #(
   parameter int NUM_SECTORS = 512,
   localparam int SEC_W = $clog2(NUM_SECTORS)
) (
   input  logic [3:0]       bp,
   input  logic             dir,
   input  logic [SEC_W-1:0] sector,
   output logic             hit
);
   logic [31:0] raw_cnt, cnt, sec32;

   always_comb begin
      sec32   = 32'(sector);
      raw_cnt = (bp == 4'd0) ? 32'd0 : (32'd1 << (bp - 4'd1));
      cnt     = (raw_cnt > 32'(NUM_SECTORS)) ? 32'(NUM_SECTORS) : raw_cnt;
      if (cnt == 32'd0) hit = 1'b0;
      else if (dir)     hit = sec32 < cnt;
      else              hit = (sec32 + cnt) >= 32'(NUM_SECTORS);
   end
endmodule

// File: rtl/wp_prog_path.sv
module wp_prog_path #(
   parameter int ADDR_W = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              deny,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic [7:0]        rdata,
   output logic              we_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [7:0]        wdata_o,
   output logic              err_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_o    <= 1'b0;
         err_o   <= 1'b0;
         addr_o  <= '0;
         wdata_o <= '0;
      end else begin
         we_o  <= go && !deny;
         err_o <= go && deny;
         if (go && !deny) begin
            addr_o  <= addr;
            wdata_o <= wdata & rdata;
         end
      end
   end
endmodule

// File: rtl/spi_wp_guard.sv
module spi_wp_guard
   import spi_wp_pkg::*;
#(
   parameter int SECTOR_LOG2 = 16,
   parameter int NUM_SECTORS = 512,
   parameter bit HAS_DIR     = 1'b1,
   parameter bit HAS_BP3     = 1'b1,
   localparam int SEC_W  = $clog2(NUM_SECTORS),
   localparam int ADDR_W = SECTOR_LOG2 + SEC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_op,
   input  logic [7:0]        cmd_data,
   input  logic              prog_valid,
   input  logic [ADDR_W-1:0] prog_addr,
   input  logic [7:0]        prog_data,
   input  logic [7:0]        mem_rdata,
   output logic              sr_rd_valid,
   output logic [7:0]        sr_rd_data,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              prot_err
);
   generate
      if (NUM_SECTORS < 2)
         $error("spi_wp_guard: NUM_SECTORS must be at least 2");
      if (SEC_W > 24)
         $error("spi_wp_guard: NUM_SECTORS too large");
      if (SECTOR_LOG2 < 1)
         $error("spi_wp_guard: SECTOR_LOG2 must be positive");
   endgenerate

   wp_sr_t           sr;
   logic [7:0]       sr_q;
   logic             is_wrsr, do_wrsr, prog_go, clr_wel, set_wel, deny;
   logic [SEC_W-1:0] sector;

   assign sr_q    = sr;
   assign is_wrsr = cmd_valid && (cmd_op == OP_WRSR);
   assign do_wrsr = is_wrsr && sr.wel;
   assign set_wel = cmd_valid && (cmd_op == OP_WREN);
   assign prog_go = prog_valid && !cmd_valid && sr.wel;
   assign clr_wel = (cmd_valid && (cmd_op == OP_WRDI)) || do_wrsr || prog_go;
   assign sector  = prog_addr[ADDR_W-1 -: SEC_W];

   wp_status_reg #(.HAS_DIR(HAS_DIR), .HAS_BP3(HAS_BP3)) u_sr (
      .clk(clk), .rst_n(rst_n), .load(do_wrsr), .load_val(cmd_data),
      .set_wel(set_wel), .clr_wel(clr_wel), .sr(sr)
   );

   wp_range_check #(.NUM_SECTORS(NUM_SECTORS)) u_rng (
      .bp({sr.bp3, sr.bp_lo}), .dir(sr.dir), .sector(sector), .hit(deny)
   );

   wp_prog_path #(.ADDR_W(ADDR_W)) u_prog (
      .clk(clk), .rst_n(rst_n), .go(prog_go), .deny(deny),
      .addr(prog_addr), .wdata(prog_data), .rdata(mem_rdata),
      .we_o(mem_we), .addr_o(mem_addr), .wdata_o(mem_wdata), .err_o(prot_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_rd_valid <= 1'b0;
         sr_rd_data  <= '0;
      end else begin
         sr_rd_valid <= cmd_valid && (cmd_op == OP_RDSR);
         if (cmd_valid && (cmd_op == OP_RDSR)) sr_rd_data <= sr;
      end
   end
endmodule

// File: rtl/spi_wp_guard_chk.sv
module spi_wp_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       has_dir,
   input logic       has_bp3,
   input logic       cmd_valid,
   input logic [7:0] cmd_op,
   input logic       prog_valid,
   input logic       sr_rd_valid,
   input logic [7:0] sr_rd_data,
   input logic [7:0] sr_q,
   input logic       mem_we,
   input logic       prot_err
);
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (sr_q == 8'h00));
   a_r2_rd_cause: assert property (@(posedge clk) disable iff (!rst_n)
      sr_rd_valid |-> $past(cmd_valid && cmd_op == 8'h05));
   a_r3_wel_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 8'h01 && sr_q[1]) |=> !sr_q[1]);
   a_r4_dir_absent: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_rd_valid && !has_dir) |-> !sr_rd_data[5]);
   a_r5_bp3_absent: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_rd_valid && !has_bp3) |-> !sr_rd_data[6]);
   a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && prot_err));
   a_r10_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || prot_err) |-> $past(prog_valid && sr_q[1]));
   a_r11_no_wel: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_valid && !cmd_valid && !sr_q[1]) |=> (!mem_we && !prot_err));
endmodule

bind spi_wp_guard spi_wp_guard_chk chk_i (
   .clk(clk), .rst_n(rst_n), .has_dir(HAS_DIR != 1'b0), .has_bp3(HAS_BP3 != 1'b0),
   .cmd_valid(cmd_valid), .cmd_op(cmd_op), .prog_valid(prog_valid),
   .sr_rd_valid(sr_rd_valid), .sr_rd_data(sr_rd_data), .sr_q(sr_q),
   .mem_we(mem_we), .prot_err(prot_err)
);

// File: tb/spi_wp_guard_tb_top.sv
module spi_wp_guard_tb_top;
   localparam int AW = 25;
   localparam int NS = 512;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 1'b0, prog_valid = 1'b0;
   logic [7:0] cmd_op = '0, cmd_data = '0, prog_data = '0, mem_rdata = '0;
   logic [AW-1:0] prog_addr = '0;
   logic rv[2], we[2], er[2];
   logic [7:0] rd[2], wd[2];
   logic [AW-1:0] wa[2];
   int checks = 0, fails = 0;
   bit m_wel[2], m_dir[2], m_wdis[2];
   logic [3:0] m_bp[2];

   always #10 clk = ~clk;

   spi_wp_guard dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
      .prog_valid(prog_valid), .prog_addr(prog_addr), .prog_data(prog_data), .mem_rdata(mem_rdata),
      .sr_rd_valid(rv[0]), .sr_rd_data(rd[0]), .mem_we(we[0]), .mem_addr(wa[0]),
      .mem_wdata(wd[0]), .prot_err(er[0]));

   spi_wp_guard #(.HAS_DIR(1'b0), .HAS_BP3(1'b0)) dut_plain_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
      .prog_valid(prog_valid), .prog_addr(prog_addr), .prog_data(prog_data), .mem_rdata(mem_rdata),
      .sr_rd_valid(rv[1]), .sr_rd_data(rd[1]), .mem_we(we[1]), .mem_addr(wa[1]),
      .mem_wdata(wd[1]), .prot_err(er[1]));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_sr(input int k);
      return {m_wdis[k], m_bp[k][3], m_dir[k], m_bp[k][2:0], m_wel[k], 1'b0};
   endfunction

   function automatic bit is_prot(input logic [3:0] bp, input bit dir, input int sec);
      longint c;
      if (bp == 0) return 1'b0;
      c = longint'(1) << (bp - 1);
      if (c > NS) c = NS;
      if (dir) return sec < c;
      return (sec + c) >= NS;
   endfunction

   task automatic cmd(input logic [7:0] op, input logic [7:0] d, input string req);
      cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
         if (op == 8'h05) begin
            chk(rv[k] == 1'b1, req, {31'd0, rv[k]}, 32'd1);
            chk(rd[k] == exp_sr(k), req, {24'd0, rd[k]}, {24'd0, exp_sr(k)});
         end else begin
            chk(rv[k] == 1'b0, req, {31'd0, rv[k]}, 32'd0);
         end
         case (op)
            8'h06: m_wel[k] = 1'b1;
            8'h04: m_wel[k] = 1'b0;
            8'h01: if (m_wel[k]) begin
               m_wel[k]  = 1'b0;
               m_wdis[k] = d[7];
               m_bp[k]   = {(k == 0) ? d[6] : 1'b0, d[4:2]};
               m_dir[k]  = (k == 0) ? d[5] : 1'b0;
            end
            default: ;
         endcase
      end
      cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0;
   endtask

   task automatic prog(input int sec, input logic [15:0] off, input logic [7:0] d,
                       input logic [7:0] old, input string req);
      logic [AW-1:0] a;
      bit pr;
      a = {sec[8:0], off};
      prog_valid = 1'b1; prog_addr = a; prog_data = d; mem_rdata = old;
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
         pr = is_prot(m_bp[k], m_dir[k], sec);
         chk(we[k] == (m_wel[k] && !pr), req, {31'd0, we[k]}, {31'd0, m_wel[k] && !pr});
         chk(er[k] == (m_wel[k] && pr), req, {31'd0, er[k]}, {31'd0, m_wel[k] && pr});
         if (m_wel[k] && !pr) begin
            chk(wa[k] == a, req, 32'(wa[k]), 32'(a));
            chk(wd[k] == (d & old), req, {24'd0, wd[k]}, {24'd0, d & old});
         end
         m_wel[k] = 1'b0;
      end
      prog_valid = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int sec, op;
      void'($urandom(32'h5EED_0B1E));
      for (int k = 0; k < 2; k++) begin
         m_wel[k] = 0; m_dir[k] = 0; m_wdis[k] = 0; m_bp[k] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
         chk(we[k] == 0 && er[k] == 0, "R1 idle outputs", {30'd0, we[k], er[k]}, 32'd0);
      end
      cmd(8'h05, 8'h00, "R1 reset status");
      cmd(8'h06, 8'h00, "R2 set latch");
      cmd(8'h05, 8'h00, "R2 read latch");
      cmd(8'h04, 8'h00, "R2 clear latch");
      cmd(8'h05, 8'h00, "R2 read cleared");
      cmd(8'h01, 8'hFC, "R3 write without latch");
      cmd(8'h05, 8'h00, "R3 ignored write");
      cmd(8'h06, 8'h00, "R3 latch");
      cmd(8'h01, 8'h9C, "R3 write");
      cmd(8'h05, 8'h00, "R3 stored bits");
      cmd(8'h06, 8'h00, "R4 latch");
      cmd(8'h01, 8'h60, "R4 R5 write optional bits");
      cmd(8'h05, 8'h00, "R4 R5 optional bits read");
      cmd(8'h06, 8'h00, "R6 latch");
      cmd(8'h01, 8'h00, "R6 clear protection");
      cmd(8'h06, 8'h00, "R6 latch");
      prog(NS - 1, 16'hFFFF, 8'hA5, 8'hF0, "R6 no protection");
      cmd(8'h06, 8'h00, "R7 latch");
      cmd(8'h01, 8'h04, "R7 bp1 top");
      cmd(8'h06, 8'h00, "R7 latch");
      prog(NS - 1, 16'h0000, 8'h3C, 8'hFF, "R7 top sector denied");
      cmd(8'h06, 8'h00, "R7 latch");
      prog(NS - 2, 16'h1234, 8'h3C, 8'h0F, "R7 next sector allowed");
      cmd(8'h06, 8'h00, "R8 latch");
      cmd(8'h01, 8'h24, "R8 bp1 bottom");
      cmd(8'h06, 8'h00, "R8 latch");
      prog(0, 16'h0010, 8'h55, 8'hFF, "R8 bottom sector denied");
      cmd(8'h06, 8'h00, "R8 latch");
      prog(1, 16'h0000, 8'h55, 8'hFF, "R8 sector one allowed");
      cmd(8'h06, 8'h00, "R9 latch");
      cmd(8'h01, 8'h58, "R9 bp14");
      cmd(8'h06, 8'h00, "R9 latch");
      prog(0, 16'h0000, 8'h00, 8'hFF, "R9 saturated count");
      cmd(8'h06, 8'h00, "R9 latch");
      cmd(8'h01, 8'h7C, "R9 bp15");
      cmd(8'h06, 8'h00, "R9 latch");
      prog(0, 16'h0001, 8'h11, 8'hFF, "R9 saturated count max");
      prog(5, 16'h0001, 8'h11, 8'hFF, "R11 program without latch");
      cmd(8'h05, 8'h00, "R11 latch state");
      for (int i = 0; i < 600; i++) begin
         op = $urandom_range(0, 9);
         if (op < 3) cmd(8'h06, 8'h00, "R2 random latch");
         else if (op == 3) cmd(8'h01, 8'($urandom), "R3 random write");
         else if (op == 4) cmd(8'h05, 8'h00, "R2 random read");
         else if (op == 5) cmd(8'h04, 8'h00, "R2 random clear");
         else begin
            sec = ($urandom_range(0, 1) == 0) ? $urandom_range(0, 70) : $urandom_range(NS - 70, NS - 1);
            if ($urandom_range(0, 3) == 0) sec = $urandom_range(0, NS - 1);
            prog(sec, 16'($urandom), 8'($urandom), 8'($urandom), "R10 random program");
         end
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule